// File: doc/BRIEF.md
# Two-Line Collapsing Fetch Aligner

This block builds one fetch group for a wide front end. In a single cycle two instruction lines arrive together, one from each of two interleaved cache banks. Each line holds four 32-bit instruction slots. Each slot has a valid bit. A slot is invalid when it lies ahead of the fetch entry point or beyond a branch that is predicted taken. A select input says which bank holds the line that comes first in predicted program order.

The block works in three steps. First it swaps the two lines so that the leading line sits in front. Next it removes every invalid slot and packs the survivors into output slot 0 upward, keeping program order. Finally it registers the result. At most four instructions leave per group. Any extra valid instructions are reported as a dropped count.

Both edges of the block use valid/ready handshakes. A group is accepted on a clock edge where `in_valid` and `in_ready` are both high. The packed result appears on the outputs after that same edge. It stays unchanged until the consumer takes it on an edge where `out_valid` and `out_ready` are both high. The input is ready whenever the output register is empty or is being drained in that cycle.

Top module: `cbfa_fetch_aligner`

## Requirements
- R1: While reset is asserted, and after it is released with no input accepted, `out_valid` is 0.
- R2: When `in_first_bank` is 0 the line from bank 0 leads program order; when it is 1 the line from bank 1 leads, whichever bank it came from.
- R3: The valid slots, taken in program order (every slot of the leading line, slot 0 to 3, then every slot of the trailing line, slot 0 to 3), are placed in output slots 0, 1, 2, 3 in that order. Output slot k occupies bits [32k+31:32k] of `out_data`. Mask bit i belongs to slot i of its line.
- R4: `out_slot_vld` has its low `out_count` bits set and every other bit clear.
- R5: `out_count` equals the number of valid input slots, capped at 4.
- R6: `out_dropped` equals the number of valid input slots minus `out_count`. It is nonzero only when `out_count` is 4.
- R7: Output slots that carry no instruction read as zero.
- R8: A group accepted on a clock edge appears on the outputs right after that edge and no earlier. The latency is one cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R10: When the output group is consumed and no new input is accepted on the same edge, `out_valid` falls to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group offered |
| in_ready | output | 1 | Block can accept a group this cycle |
| in_first_bank | input | 1 | 0: bank 0 line leads; 1: bank 1 line leads |
| in_bank0_data | input | 128 | Bank 0 line, slot s at bits [32s+31:32s] |
| in_bank0_mask | input | 4 | Per-slot valid bits for the bank 0 line |
| in_bank1_data | input | 128 | Bank 1 line, slot s at bits [32s+31:32s] |
| in_bank1_mask | input | 4 | Per-slot valid bits for the bank 1 line |
| out_valid | output | 1 | Packed group available |
| out_ready | input | 1 | Consumer takes the group this cycle |
| out_data | output | 128 | Packed instructions, output slot k at bits [32k+31:32k] |
| out_slot_vld | output | 4 | Per-output-slot valid bits |
| out_count | output | 3 | Number of delivered instructions, 0 to 4 |
| out_dropped | output | 3 | Number of valid instructions beyond the cap |

## Verification
Two cases are hard to reach from the ports: a group with more valid slots than the output can hold, and a group whose leading line is completely empty while its trailing line has valid slots. In the first case the dropped count must agree with the delivered count. In the second, packing must begin inside the trailing line. The vector table covers both cases, and covers each of them under both bank orders. Every word of input data encodes its vector, bank and slot, so any mix-up of bank order or slot order shows up in the exact words delivered.

Back-pressure is the other hard case. The bench stalls the consumer while a second group is already waiting at the input. It then checks that the held group and `in_ready` do not change until the stall is released.

// File: rtl/cbfa_pkg.sv
package cbfa_pkg;
  localparam int unsigned DEF_SLOTS  = 4;
  localparam int unsigned DEF_WORD_W = 32;

  typedef enum logic {
    LEAD_BANK0 = 1'b0,
    LEAD_BANK1 = 1'b1
  } lead_e;
endpackage

// File: rtl/cbfa_interchange.sv
module cbfa_interchange
  import cbfa_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned LINE_W = SLOTS * WORD_W
) (
  input  logic                  first_bank,
  input  logic [LINE_W-1:0]     bank0_data,
  input  logic [SLOTS-1:0]      bank0_mask,
  input  logic [LINE_W-1:0]     bank1_data,
  input  logic [SLOTS-1:0]      bank1_mask,
  output logic [2*LINE_W-1:0]   seq_data,
  output logic [2*SLOTS-1:0]    seq_mask
);
  lead_e lead;
  assign lead = lead_e'(first_bank);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      if (lead == LEAD_BANK1) begin
        seq_data[s*WORD_W +: WORD_W]         = bank1_data[s*WORD_W +: WORD_W];
        seq_data[(s+SLOTS)*WORD_W +: WORD_W] = bank0_data[s*WORD_W +: WORD_W];
        seq_mask[s]                          = bank1_mask[s];
        seq_mask[s+SLOTS]                    = bank0_mask[s];
      end else begin
        seq_data[s*WORD_W +: WORD_W]         = bank0_data[s*WORD_W +: WORD_W];
        seq_data[(s+SLOTS)*WORD_W +: WORD_W] = bank1_data[s*WORD_W +: WORD_W];
        seq_mask[s]                          = bank0_mask[s];
        seq_mask[s+SLOTS]                    = bank1_mask[s];
      end
    end
  end
endmodule

// File: rtl/cbfa_collapse.sv
module cbfa_collapse #(
  parameter int unsigned IN_SLOTS  = 8,
  parameter int unsigned OUT_SLOTS = 4,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned TOT_W  = $clog2(IN_SLOTS + 1),
  localparam int unsigned CNT_W  = $clog2(OUT_SLOTS + 1),
  localparam int unsigned DROP_W = $clog2(IN_SLOTS - OUT_SLOTS + 1)
) (
  input  logic [IN_SLOTS*WORD_W-1:0]  seq_data,
  input  logic [IN_SLOTS-1:0]         seq_mask,
  output logic [OUT_SLOTS*WORD_W-1:0] pk_data,
  output logic [OUT_SLOTS-1:0]        pk_vld,
  output logic [CNT_W-1:0]            pk_count,
  output logic [DROP_W-1:0]           pk_dropped
);
  logic [TOT_W-1:0] rank [IN_SLOTS];
  logic [TOT_W-1:0] total;

  // Position of each valid slot among the valid ones (prefix count).
  always_comb begin
    logic [TOT_W-1:0] run;
    run = '0;
    for (int i = 0; i < IN_SLOTS; i++) begin
      rank[i] = run;
      run     = run + TOT_W'(seq_mask[i]);
    end
    total = run;
  end

  // Each output slot selects the input whose rank matches its index.
  for (genvar k = 0; k < OUT_SLOTS; k++) begin : g_out
    always_comb begin
      pk_data[k*WORD_W +: WORD_W] = '0;
      pk_vld[k]                   = 1'b0;
      for (int i = 0; i < IN_SLOTS; i++) begin
        if (seq_mask[i] && (rank[i] == TOT_W'(k))) begin
          pk_data[k*WORD_W +: WORD_W] = seq_data[i*WORD_W +: WORD_W];
          pk_vld[k]                   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (total > TOT_W'(OUT_SLOTS)) begin
      pk_count   = CNT_W'(OUT_SLOTS);
      pk_dropped = DROP_W'(total - TOT_W'(OUT_SLOTS));
    end else begin
      pk_count   = CNT_W'(total);
      pk_dropped = '0;
    end
  end
endmodule

// File: rtl/cbfa_out_stage.sv
module cbfa_out_stage #(
  parameter int unsigned OUT_SLOTS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned DROP_W    = 3,
  localparam int unsigned DATA_W = OUT_SLOTS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] nx_data,
  input  logic [OUT_SLOTS-1:0] nx_vld,
  input  logic [CNT_W-1:0]  nx_count,
  input  logic [DROP_W-1:0] nx_dropped,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic [OUT_SLOTS-1:0] dn_vld,
  output logic [CNT_W-1:0]  dn_count,
  output logic [DROP_W-1:0] dn_dropped
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid   <= 1'b0;
      dn_data    <= '0;
      dn_vld     <= '0;
      dn_count   <= '0;
      dn_dropped <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_data    <= nx_data;
        dn_vld     <= nx_vld;
        dn_count   <= nx_count;
        dn_dropped <= nx_dropped;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data) && $stable(dn_count)) // R9
    else $error("held group changed under stall");

  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |-> !up_ready) // R9
    else $error("input ready while stalled");

  AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ($countones(dn_vld) == int'(dn_count)) &&
                 ((dn_vld & (dn_vld + OUT_SLOTS'(1))) == '0)) // R4
    else $error("slot valid not thermometer of count");

  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && (dn_dropped != '0) |-> dn_count == CNT_W'(OUT_SLOTS)) // R6
    else $error("drop without full group");

  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid) // R10
    else $error("valid stuck after drain");

  for (genvar k = 0; k < OUT_SLOTS; k++) begin : g_zero
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_vld[k] |-> dn_data[k*WORD_W +: WORD_W] == '0) // R7
      else $error("empty slot not zero");
  end
endmodule

// File: rtl/cbfa_fetch_aligner.sv
module cbfa_fetch_aligner
  import cbfa_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned LINE_W = SLOTS * WORD_W,
  localparam int unsigned IN_SL  = 2 * SLOTS,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned DROP_W = $clog2(IN_SL - SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first_bank,
  input  logic [LINE_W-1:0] in_bank0_data,
  input  logic [SLOTS-1:0]  in_bank0_mask,
  input  logic [LINE_W-1:0] in_bank1_data,
  input  logic [SLOTS-1:0]  in_bank1_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_data,
  output logic [SLOTS-1:0]  out_slot_vld,
  output logic [CNT_W-1:0]  out_count,
  output logic [DROP_W-1:0] out_dropped
);
  logic [2*LINE_W-1:0] seq_data;
  logic [IN_SL-1:0]    seq_mask;
  logic [LINE_W-1:0]   pk_data;
  logic [SLOTS-1:0]    pk_vld;
  logic [CNT_W-1:0]    pk_count;
  logic [DROP_W-1:0]   pk_dropped;

  cbfa_interchange #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_swap (
    .first_bank (in_first_bank),
    .bank0_data (in_bank0_data),
    .bank0_mask (in_bank0_mask),
    .bank1_data (in_bank1_data),
    .bank1_mask (in_bank1_mask),
    .seq_data   (seq_data),
    .seq_mask   (seq_mask)
  );

  cbfa_collapse #(.IN_SLOTS(IN_SL), .OUT_SLOTS(SLOTS), .WORD_W(WORD_W)) u_pack (
    .seq_data   (seq_data),
    .seq_mask   (seq_mask),
    .pk_data    (pk_data),
    .pk_vld     (pk_vld),
    .pk_count   (pk_count),
    .pk_dropped (pk_dropped)
  );

  cbfa_out_stage #(.OUT_SLOTS(SLOTS), .WORD_W(WORD_W), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (in_valid),
    .up_ready   (in_ready),
    .nx_data    (pk_data),
    .nx_vld     (pk_vld),
    .nx_count   (pk_count),
    .nx_dropped (pk_dropped),
    .dn_valid   (out_valid),
    .dn_ready   (out_ready),
    .dn_data    (out_data),
    .dn_vld     (out_slot_vld),
    .dn_count   (out_count),
    .dn_dropped (out_dropped)
  );

  AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=>
      (int'(out_count) + int'(out_dropped)) ==
      $past($countones({in_bank1_mask, in_bank0_mask}))) // R5
    else $error("delivered plus dropped differs from valid input");

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) // R8
    else $error("accepted group not presented");
endmodule

// File: tb/tb_cbfa_fetch_aligner.sv
module tb_cbfa_fetch_aligner;
  localparam int NV = 12;
  // entry = {first_bank, bank1_mask, bank0_mask}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1111_1111, 9'b1_1111_1111, 9'b0_0011_1100, 9'b1_1000_0001,
    9'b0_0000_0000, 9'b0_1010_0111, 9'b1_0101_0110, 9'b0_0110_0000,
    9'b1_0000_1000, 9'b0_0001_1011, 9'b1_1110_0100, 9'b0_0000_1111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first_bank = 1'b0, out_ready = 1'b1;
  logic [127:0] in_bank0_data = '0, in_bank1_data = '0;
  logic [3:0] in_bank0_mask = '0, in_bank1_mask = '0;
  logic in_ready, out_valid;
  logic [127:0] out_data;
  logic [3:0] out_slot_vld;
  logic [2:0] out_count, out_dropped;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cbfa_fetch_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first_bank(in_first_bank), .in_bank0_data(in_bank0_data),
    .in_bank0_mask(in_bank0_mask), .in_bank1_data(in_bank1_data),
    .in_bank1_mask(in_bank1_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_slot_vld(out_slot_vld), .out_count(out_count),
    .out_dropped(out_dropped)
  );

  function automatic logic [31:0] word(int v, int b, int s);
    return {16'(v + 1), 8'(b), 8'(s)};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int v, logic [8:0] e);
    in_first_bank = e[8];
    in_bank1_mask = e[7:4];
    in_bank0_mask = e[3:0];
    for (int s = 0; s < 4; s++) begin
      in_bank0_data[s*32 +: 32] = word(v, 0, s);
      in_bank1_data[s*32 +: 32] = word(v, 1, s);
    end
    in_valid = 1'b1;
  endtask

  // Model: leading line then trailing line, slots 0..3, keep first four.
  task automatic check_vec(int v, logic [8:0] e);
    logic [127:0] ed = '0;
    logic [3:0] ev = '0;
    int n = 0;
    int lead = e[8] ? 1 : 0;
    string tag = e[8] ? "R2/R3 bank1-leads" : "R3 bank0-leads";
    for (int l = 0; l < 2; l++) begin
      int b = (l == 0) ? lead : 1 - lead;
      for (int s = 0; s < 4; s++) begin
        logic vb = (b == 0) ? e[s] : e[4+s];
        if (vb) begin
          if (n < 4) begin
            ed[n*32 +: 32] = word(v, b, s);
            ev[n] = 1'b1;
          end
          n++;
        end
      end
    end
    chk("R8 out_valid", 128'(out_valid), 128'(1));
    chk(tag, out_data, ed);                       // R7 zero fill included
    chk("R4 slot_vld", 128'(out_slot_vld), 128'(ev));
    chk("R5 count", 128'(out_count), 128'((n > 4) ? 4 : n));
    chk("R6 dropped", 128'(out_dropped), 128'((n > 4) ? n - 4 : 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset valid", 128'(out_valid), 128'(0));
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 idle after reset", 128'(out_valid), 128'(0));

    // Table walk, streaming with consumer always ready.
    for (int v = 0; v < NV; v++) begin
      @(negedge clk) drive(v, VEC[v]);
      if (v == 0) chk("R8 not before edge", 128'(out_valid), 128'(0));
      @(posedge clk); #1 check_vec(v, VEC[v]);
    end
    @(negedge clk) in_valid = 1'b0;
    @(posedge clk); #1 chk("R10 drained", 128'(out_valid), 128'(0));

    // Back-pressure: hold group A while group B waits.
    @(negedge clk) begin out_ready = 1'b0; drive(20, 9'b0_0011_0110); end
    @(posedge clk); #1 check_vec(20, 9'b0_0011_0110);
    @(negedge clk) drive(21, 9'b1_1001_0010);
    #1 chk("R9 in_ready low", 128'(in_ready), 128'(0));
    @(posedge clk); #1 check_vec(20, 9'b0_0011_0110);   // R9 held
    chk("R9 still not ready", 128'(in_ready), 128'(0));
    @(negedge clk) out_ready = 1'b1;
    #1 chk("R10 ready on drain", 128'(in_ready), 128'(1));
    @(posedge clk); #1 check_vec(21, 9'b1_1001_0010);
    @(negedge clk) in_valid = 1'b0;
    @(posedge clk); #1 chk("R10 empty after consume", 128'(out_valid), 128'(0));

    // Mid-run reset clears the output register.
    @(negedge clk) drive(30, 9'b0_1111_0001);
    @(posedge clk); #1 chk("R8 present", 128'(out_valid), 128'(1));
    @(negedge clk) begin in_valid = 1'b0; rst_n = 1'b0; end
    #1 chk("R1 reset clears", 128'(out_valid), 128'(0));
    @(negedge clk) rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule